// File: doc/BRIEF.md
# Spectral Bin Power Classifier

This block sits downstream of an FFT engine and a magnitude-squaring stage. It receives the squared-magnitude bins of one N-point record as a stream, starting at bin 0. The record holds a whole number of cycles of a test tone, so the tone lands exactly on one bin, the fundamental bin. Each bin is sorted into one of four classes: DC, signal, harmonic or noise. The block adds up noise power and distortion power over the record and keeps the largest single harmonic bin.

Harmonic order k sits at k times the fundamental bin. That index is reduced modulo N, and when the result lies above N/2 it is mirrored to N minus the result. This models a tone above half the sample rate aliasing back into the first Nyquist zone. Only bins 0 through N/2 carry information, because the upper half of a real-input spectrum mirrors the lower half.

When the record-end marker arrives, the block presents the signal power, the noise sum, the distortion sum and the largest spur. Downstream arithmetic turns these into SNR, SDR, SNDR and SFDR. The block also raises a length error flag when the record was not exactly N/2+1 bins long.

Top module: `spec_bin_sorter`

## Requirements
- R1: After reset, `res_valid`, `res_len_err` and every result output are 0.
- R2: Bins that arrive after bin N/2 (counting from bin 0) within one record are left out of every result.
- R3: `res_sig_pwr` reports the power of the bin whose index equals the fundamental bin.
- R4: The bin for harmonic order k is (k·f mod N), where f is the fundamental bin. If that value exceeds N/2, the bin is N minus that value.
- R5: A harmonic that folds onto bin 0 or onto the fundamental bin adds nothing to distortion. A bin that several orders fold onto is counted once.
- R6: `res_noise_sum` is the sum of the powers of all bins from 1 to N/2, except the fundamental bin and the harmonic bins.
- R7: `res_dist_sum` is the sum of the powers of the distinct harmonic bins, accumulated to 48 bits without loss for 32-bit inputs.
- R8: `res_spur_max` is the largest single harmonic bin power, and 0 when no harmonic bin exists.
- R9: `res_valid` pulses for exactly one cycle, in the cycle after the bin that carries `in_last`. The results hold until the next record end, and each record starts from cleared sums.
- R10: `res_len_err` is 1 when the record-end marker arrives on a bin other than bin N/2, and 0 otherwise.
- R11: Harmonic orders 2 up to `cfg_harm_max` are used. Values above 9 act as 9, and values below 2 select no harmonics.
- R12: `cfg_fund_bin` and `cfg_harm_max` are sampled with bin 0 of each record. Changes during the rest of the record have no effect on that record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fund_bin | input | LOG2N (6) | Fundamental bin index, 1 to N/2-1 |
| cfg_harm_max | input | HSEL_W (4) | Highest harmonic order to classify |
| in_valid | input | 1 | A bin is presented this cycle |
| in_power | input | PWR_W (32) | Squared magnitude of the bin, unsigned |
| in_last | input | 1 | Marks the last bin of the record |
| res_valid | output | 1 | One-cycle strobe: new results |
| res_sig_pwr | output | PWR_W (32) | Power of the fundamental bin |
| res_noise_sum | output | ACC_W (48) | Sum of noise bin powers |
| res_dist_sum | output | ACC_W (48) | Sum of harmonic bin powers |
| res_spur_max | output | PWR_W (32) | Largest harmonic bin power |
| res_len_err | output | 1 | Record length was not N/2+1 bins |

## Verification
On every cycle, the bound checker confirms four things. A result strobe follows an accepted record-end bin. The results never move except under that strobe. The spur never exceeds the distortion sum. The length flag agrees with an independent bin count kept in the checker. The harmonic folding, the exclusion of DC and signal collisions, duplicate suppression, order clamping, configuration sampling and the exact sums can only be shown by the bench. It drives records with known bin powers and compares the results against sums it computes from the requirements.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    BIN_DC    = 3'd0,
    BIN_SIG   = 3'd1,
    BIN_HARM  = 3'd2,
    BIN_NOISE = 3'd3,
    BIN_DROP  = 3'd4
  } bin_kind_e;

endpackage

// File: rtl/sbs_harm_map.sv
// Builds the per-bin harmonic mark bitmap for the positive half spectrum.
module sbs_harm_map #(
  parameter int LOG2N    = 6,
  parameter int MAX_HARM = 9,
  parameter int HSEL_W   = 4
) (
  input  logic [LOG2N-1:0]      fund_i,
  input  logic [HSEL_W-1:0]     hmax_i,
  output logic [2**(LOG2N-1):0] mark_o
);
  localparam int HALF = 2**(LOG2N-1);
  localparam int PW   = LOG2N + HSEL_W;

  logic [HSEL_W-1:0] hlim;
  logic [LOG2N-1:0]  fold_a [MAX_HARM:2];
  logic [MAX_HARM:2] en_a;

  assign hlim = (hmax_i > HSEL_W'(MAX_HARM)) ? HSEL_W'(MAX_HARM) : hmax_i;

  for (genvar k = 2; k <= MAX_HARM; k++) begin : g_ord
    logic [PW-1:0]    prod;
    logic [LOG2N-1:0] wrap;
    // k*f modulo N is the low LOG2N bits, since N is a power of two
    assign prod      = PW'(fund_i) * PW'(k);
    assign wrap      = prod[LOG2N-1:0];
    // mirror into the first Nyquist zone
    assign fold_a[k] = (wrap > LOG2N'(HALF)) ? (~wrap + 1'b1) : wrap;
    assign en_a[k]   = (HSEL_W'(k) <= hlim);
  end

  always_comb begin
    mark_o = '0;
    for (int k = 2; k <= MAX_HARM; k++) begin
      if (en_a[k] && (fold_a[k] != '0) && (fold_a[k] != fund_i)) begin
        mark_o[fold_a[k]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbs_bin_track.sv
// Tracks the bin index of the stream and classifies the current bin.
module sbs_bin_track
  import sbs_pkg::*;
#(
  parameter int LOG2N = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_i,
  input  logic                  last_i,
  input  logic [LOG2N-1:0]      fund_i,
  input  logic [2**(LOG2N-1):0] mark_i,
  output bin_kind_e             kind_o,
  output logic                  len_bad_o
);
  localparam int HALF = 2**(LOG2N-1);

  logic [LOG2N-1:0]  cnt_q, cnt_d;
  logic [LOG2N-1:0]  fund_q;
  logic [HALF:0]     mark_q;
  logic              cnt_en, cfg_en;

  assign cnt_en = valid_i;
  assign cfg_en = valid_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (last_i) begin
      cnt_d = '0;
    end else if (cnt_q <= LOG2N'(HALF)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fund_q <= '0;
      mark_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (cfg_en) begin
        fund_q <= fund_i;
        mark_q <= mark_i;
      end
    end
  end

  always_comb begin
    if (cnt_q > LOG2N'(HALF))      kind_o = BIN_DROP;
    else if (cnt_q == '0)          kind_o = BIN_DC;
    else if (cnt_q == fund_q)      kind_o = BIN_SIG;
    else if (mark_q[cnt_q])        kind_o = BIN_HARM;
    else                           kind_o = BIN_NOISE;
  end

  assign len_bad_o = (cnt_q != LOG2N'(HALF));

endmodule

// File: rtl/sbs_accum.sv
// Power accumulators and the result registers.
module sbs_accum
  import sbs_pkg::*;
#(
  parameter int PWR_W = 32,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [PWR_W-1:0] power_i,
  input  bin_kind_e        kind_i,
  input  logic             len_bad_i,
  output logic             res_valid_o,
  output logic [PWR_W-1:0] sig_o,
  output logic [ACC_W-1:0] noise_o,
  output logic [ACC_W-1:0] dist_o,
  output logic [PWR_W-1:0] spur_o,
  output logic             len_err_o
);
  logic [ACC_W-1:0] noise_q, noise_nx, noise_d;
  logic [ACC_W-1:0] dist_q,  dist_nx,  dist_d;
  logic [PWR_W-1:0] spur_q,  spur_nx,  spur_d;
  logic [PWR_W-1:0] sig_q,   sig_nx,   sig_d;
  logic             acc_en, out_en;

  assign acc_en = valid_i;
  assign out_en = valid_i && last_i;

  always_comb begin
    noise_nx = noise_q;
    dist_nx  = dist_q;
    spur_nx  = spur_q;
    sig_nx   = sig_q;
    unique case (kind_i)
      BIN_SIG:   sig_nx = power_i;
      BIN_HARM: begin
        dist_nx = dist_q + ACC_W'(power_i);
        if (power_i > spur_q) spur_nx = power_i;
      end
      BIN_NOISE: noise_nx = noise_q + ACC_W'(power_i);
      default: ;
    endcase
  end

  always_comb begin
    noise_d = out_en ? '0 : noise_nx;
    dist_d  = out_en ? '0 : dist_nx;
    spur_d  = out_en ? '0 : spur_nx;
    sig_d   = out_en ? '0 : sig_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noise_q     <= '0;
      dist_q      <= '0;
      spur_q      <= '0;
      sig_q       <= '0;
      noise_o     <= '0;
      dist_o      <= '0;
      spur_o      <= '0;
      sig_o       <= '0;
      len_err_o   <= 1'b0;
      res_valid_o <= 1'b0;
    end else begin
      if (acc_en) begin
        noise_q <= noise_d;
        dist_q  <= dist_d;
        spur_q  <= spur_d;
        sig_q   <= sig_d;
      end
      if (out_en) begin
        noise_o   <= noise_nx;
        dist_o    <= dist_nx;
        spur_o    <= spur_nx;
        sig_o     <= sig_nx;
        len_err_o <= len_bad_i;
      end
      res_valid_o <= out_en;
    end
  end

endmodule

// File: rtl/spec_bin_sorter.sv
module spec_bin_sorter
  import sbs_pkg::*;
#(
  parameter int LOG2N    = 6,
  parameter int PWR_W    = 32,
  parameter int ACC_W    = 48,
  parameter int MAX_HARM = 9,
  localparam int HSEL_W  = $clog2(MAX_HARM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG2N-1:0]  cfg_fund_bin,
  input  logic [HSEL_W-1:0] cfg_harm_max,
  input  logic              in_valid,
  input  logic [PWR_W-1:0]  in_power,
  input  logic              in_last,
  output logic              res_valid,
  output logic [PWR_W-1:0]  res_sig_pwr,
  output logic [ACC_W-1:0]  res_noise_sum,
  output logic [ACC_W-1:0]  res_dist_sum,
  output logic [PWR_W-1:0]  res_spur_max,
  output logic              res_len_err
);
  localparam int HALF = 2**(LOG2N-1);

  logic [HALF:0] mark_w;
  bin_kind_e     kind_w;
  logic          len_bad_w;

  sbs_harm_map #(
    .LOG2N(LOG2N), .MAX_HARM(MAX_HARM), .HSEL_W(HSEL_W)
  ) u_map (
    .fund_i (cfg_fund_bin),
    .hmax_i (cfg_harm_max),
    .mark_o (mark_w)
  );

  sbs_bin_track #(.LOG2N(LOG2N)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (in_valid),
    .last_i    (in_last),
    .fund_i    (cfg_fund_bin),
    .mark_i    (mark_w),
    .kind_o    (kind_w),
    .len_bad_o (len_bad_w)
  );

  sbs_accum #(.PWR_W(PWR_W), .ACC_W(ACC_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (in_valid),
    .last_i      (in_last),
    .power_i     (in_power),
    .kind_i      (kind_w),
    .len_bad_i   (len_bad_w),
    .res_valid_o (res_valid),
    .sig_o       (res_sig_pwr),
    .noise_o     (res_noise_sum),
    .dist_o      (res_dist_sum),
    .spur_o      (res_spur_max),
    .len_err_o   (res_len_err)
  );

endmodule

// File: rtl/spec_bin_sorter_chk.sv
module spec_bin_sorter_chk #(
  parameter int LOG2N = 6,
  parameter int PWR_W = 32,
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             res_valid,
  input logic [ACC_W-1:0] res_noise_sum,
  input logic [ACC_W-1:0] res_dist_sum,
  input logic [PWR_W-1:0] res_spur_max,
  input logic             res_len_err
);
  localparam int HALF = 2**(LOG2N-1);

  logic [LOG2N-1:0] seen_q;
  logic             exp_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= '0;
      exp_err_q <= 1'b0;
    end else if (in_valid) begin
      if (in_last) begin
        seen_q    <= '0;
        exp_err_q <= (seen_q != LOG2N'(HALF));
      end else if (seen_q <= LOG2N'(HALF)) begin
        seen_q <= seen_q + 1'b1;
      end
    end
  end

  // R9
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_last));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_noise_sum) && $stable(res_dist_sum) && $stable(res_spur_max)));

  // R8
  spur_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (ACC_W'(res_spur_max) <= res_dist_sum));

  // R8
  spur_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_dist_sum == '0)) |-> (res_spur_max == '0));

  // R10
  len_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_len_err == exp_err_q));

endmodule

bind spec_bin_sorter spec_bin_sorter_chk #(
  .LOG2N(LOG2N), .PWR_W(PWR_W), .ACC_W(ACC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_last       (in_last),
  .res_valid     (res_valid),
  .res_noise_sum (res_noise_sum),
  .res_dist_sum  (res_dist_sum),
  .res_spur_max  (res_spur_max),
  .res_len_err   (res_len_err)
);

// File: tb/spec_bin_sorter_tb.sv
module spec_bin_sorter_tb_top;
  localparam int NPTS  = 64;
  localparam int HALFB = 32;

  typedef struct packed {
    int fund;
    int hmax;
    int alt_fund;
    int alt_hmax;
    int len;
    int seed;
    int gap;
  } vec_t;

  // fund, hmax, fund after bin 0, hmax after bin 0, bins sent, seed, gaps
  localparam vec_t VECS [9] = '{
    '{5,  9,  5,  9,  33, 1, 0},   // R4 R6 R7 R8: nine orders, 35->29, 40->24, 45->19
    '{13, 5,  13, 5,  33, 2, 1},   // R4: 39->25, 52->12, 65->1; idle gaps
    '{16, 9,  16, 9,  33, 3, 0},   // R5: folds onto signal and DC, bin 32 several times
    '{21, 1,  21, 1,  33, 4, 0},   // R11: no harmonics
    '{3,  15, 3,  15, 33, 5, 0},   // R11: clamped to order 9
    '{7,  4,  7,  4,  20, 6, 0},   // R10: short record
    '{9,  3,  9,  3,  40, 7, 0},   // R2 R10: long record, extra bins ignored
    '{11, 9,  11, 9,  33, 0, 0},   // R7: large powers, wide sums
    '{5,  9,  8,  2,  33, 8, 1}    // R12: config changes after bin 0
  };

  logic        clk;
  logic        rst_n;
  logic [5:0]  cfg_fund_bin;
  logic [3:0]  cfg_harm_max;
  logic        in_valid;
  logic [31:0] in_power;
  logic        in_last;
  logic        res_valid;
  logic [31:0] res_sig_pwr;
  logic [47:0] res_noise_sum;
  logic [47:0] res_dist_sum;
  logic [31:0] res_spur_max;
  logic        res_len_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  spec_bin_sorter dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_fund_bin  (cfg_fund_bin),
    .cfg_harm_max  (cfg_harm_max),
    .in_valid      (in_valid),
    .in_power      (in_power),
    .in_last       (in_last),
    .res_valid     (res_valid),
    .res_sig_pwr   (res_sig_pwr),
    .res_noise_sum (res_noise_sum),
    .res_dist_sum  (res_dist_sum),
    .res_spur_max  (res_spur_max),
    .res_len_err   (res_len_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [31:0] pw(input int i, input int seed);
    if (seed == 0) return 32'hFFFF_FF00 - 32'(i);
    return 32'(seed * 1000 + (i * i * 7) % 997);
  endfunction

  task automatic model(input vec_t v, output logic [63:0] e_sig, output logic [63:0] e_noise,
                       output logic [63:0] e_dist, output logic [63:0] e_spur,
                       output logic [63:0] e_err);
    bit mk [0:HALFB];
    int hm;
    for (int i = 0; i <= HALFB; i++) mk[i] = 0;
    hm = (v.hmax > 9) ? 9 : v.hmax;
    for (int k = 2; k <= hm; k++) begin
      int p;
      p = (k * v.fund) % NPTS;
      if (p > HALFB) p = NPTS - p;
      if (p != 0 && p != v.fund) mk[p] = 1;
    end
    e_sig = 0; e_noise = 0; e_dist = 0; e_spur = 0;
    e_err = (v.len != HALFB + 1) ? 64'd1 : 64'd0;
    for (int i = 1; i < v.len && i <= HALFB; i++) begin
      logic [31:0] w;
      w = pw(i, v.seed);
      if (i == v.fund) e_sig = 64'(w);
      else if (mk[i]) begin
        e_dist += 64'(w);
        if (64'(w) > e_spur) e_spur = 64'(w);
      end else e_noise += 64'(w);
    end
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    logic [63:0] e_sig, e_noise, e_dist, e_spur, e_err;
    string tag;
    tag = $sformatf("vec%0d", idx);
    model(v, e_sig, e_noise, e_dist, e_spur, e_err);
    @(negedge clk);
    cfg_fund_bin = 6'(v.fund);
    cfg_harm_max = 4'(v.hmax);
    for (int i = 0; i < v.len; i++) begin
      @(negedge clk);
      if (i == 1) begin
        cfg_fund_bin = 6'(v.alt_fund);
        cfg_harm_max = 4'(v.alt_hmax);
      end
      in_valid = 1'b1;
      in_power = pw(i, v.seed);
      in_last  = (i == v.len - 1);
      if (v.gap != 0 && (i % 2) == 1 && i != v.len - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk("R9",  {tag, " strobe"},     64'(res_valid),     64'd1);
    chk("R3",  {tag, " signal"},     64'(res_sig_pwr),   e_sig);
    chk("R6",  {tag, " noise"},      64'(res_noise_sum), e_noise);
    chk("R7",  {tag, " distortion"}, 64'(res_dist_sum),  e_dist);
    chk("R8",  {tag, " spur"},       64'(res_spur_max),  e_spur);
    chk("R10", {tag, " len_err"},    64'(res_len_err),   e_err);
    @(negedge clk);
    chk("R9",  {tag, " strobe ends"}, 64'(res_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [47:0] hold_noise;
    rst_n        = 1'b0;
    cfg_fund_bin = '0;
    cfg_harm_max = '0;
    in_valid     = 1'b0;
    in_power     = '0;
    in_last      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "res_valid",     64'(res_valid),     64'd0);
    chk("R1", "res_sig_pwr",   64'(res_sig_pwr),   64'd0);
    chk("R1", "res_noise_sum", 64'(res_noise_sum), 64'd0);
    chk("R1", "res_dist_sum",  64'(res_dist_sum),  64'd0);
    chk("R1", "res_spur_max",  64'(res_spur_max),  64'd0);
    chk("R1", "res_len_err",   64'(res_len_err),   64'd0);

    for (int n = 0; n < 9; n++) run_vec(n, VECS[n]);

    // R9: results hold while no record ends
    hold_noise = res_noise_sum;
    repeat (4) @(negedge clk);
    chk("R9", "noise held",  64'(res_noise_sum), 64'(hold_noise));
    chk("R9", "no strobe",   64'(res_valid),     64'd0);

    // R9: back-to-back record starts from cleared sums
    run_vec(9, VECS[0]);

    done = 1;
    summary();
    $finish;
  end

endmodule